// File: doc/BRIEF.md
# Four-Channel Serial ADC Conversion Sequencer

This block runs an 8-bit serial analog-to-digital converter that is shared by four audio inputs. A single frame tick starts a sweep. The sweep performs one conversion on each of channels 0, 1, 2 and 3, in that order. Each conversion proceeds as follows:

- Chip select is pulled low.
- A 5-bit setup word is shifted into the converter, most significant bit first. The word holds a start bit, a single-ended/differential select bit and a 3-bit input address.
- Eight result bits are clocked back out of the converter.
- The result appears on a parallel output for one system clock, together with its 2-bit channel index, for a downstream framer to pick up.

The serial clock is divided down from the 50 MHz system clock. Each serial clock phase lasts `HALF_DIV` system clocks. Setup bits change only while the serial clock is low, so they move on its falling edge. Result bits are captured at the instant the serial clock rises. A full sweep takes 4 × 28 × `HALF_DIV` system clocks and must fit inside one 100 µs frame (`FRAME_CYCLES`). The frame tick is issued at 10 kHz, giving each source 10,000 samples per second.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is asserted, and afterwards until the first frame tick, `adc_cs_n` is 1 and `adc_sclk`, `adc_din` and `smp_valid` are 0.
- R2: A frame tick sampled while the block is idle lowers `adc_cs_n` in the next cycle. The sweep then converts channels 0, 1, 2, 3 in that order.
- R3: While `adc_cs_n` is low, `adc_sclk` runs 13 periods. Each period is HALF_DIV cycles low followed by HALF_DIV cycles high. `adc_sclk` is 0 whenever `adc_cs_n` is 1.
- R4: During the first 5 serial clock periods of a conversion, `adc_din` carries, MSB first: 1 (start), SGL_MODE, 0, then the 2-bit channel index MSB first. `adc_din` changes only while `adc_sclk` is 0, and it is 0 after the setup word.
- R5: The 8 result bits are taken from `adc_dout` at the system clock edge where `adc_sclk` rises, in serial clock periods 6 to 13. The first bit taken becomes bit 7 of `smp_data`.
- R6: `smp_valid` is high for exactly one cycle per conversion. It rises 26×HALF_DIV cycles after `adc_cs_n` falls, which is the first cycle `adc_cs_n` is back high. In that cycle `smp_chan` holds the converted channel and `smp_data` holds the result.
- R7: Between conversions `adc_cs_n` stays high for 2×HALF_DIV cycles. After channel 3 the block goes idle with `adc_cs_n` high until the next frame tick.
- R8: A frame tick that arrives during a sweep has no effect on the sweep's timing or data.
- R9: A sweep, from its tick to its return to idle, never exceeds FRAME_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Starts a four-channel sweep when idle |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_din | output | 1 | Serial setup bit to the converter |
| smp_data | output | 8 | Converted byte |
| smp_chan | output | 2 | Channel index of `smp_data` |
| smp_valid | output | 1 | One-cycle strobe marking a new byte |

## Verification
The assertions check the following on every cycle:

- A tick taken while idle opens chip select in the next cycle.
- The serial clock never toggles while chip select is released.
- The setup line never moves while the serial clock is high.
- The byte strobe is a single cycle and coincides with a released chip select.
- A sweep stays inside its frame budget.

Other behaviours can only be shown by the bench's scenarios. These are the exact phase lengths, the bit order of the setup word, the channel order, the capture of each result bit at the rising edge, and the immunity to ticks during a sweep. The bench shows them with a converter model that decodes the address it received, returns per-channel bytes including all-zero and all-one values, and is compared cycle by cycle against a timeline model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W         = 5;
  localparam int DATA_W        = 8;
  localparam int N_CH          = 4;
  localparam int CH_W          = $clog2(N_CH);
  localparam int BITS_PER_CONV = CFG_W + DATA_W;
  localparam int HALVES_ACTIVE = 2 * BITS_PER_CONV;
  localparam int HALVES_TOTAL  = HALVES_ACTIVE + 2;
  localparam int HI_W          = $clog2(HALVES_TOTAL);

  // setup word: start, single/diff select, 3-bit address (upper bit zero)
  function automatic logic [CFG_W-1:0] cfg_word(input logic sgl, input logic [CH_W-1:0] ch);
    return {1'b1, sgl, 1'b0, ch};
  endfunction

  function automatic int unsigned sweep_cycles(input int unsigned half);
    return N_CH * HALVES_TOTAL * half;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [CH_W-1:0] chan,
  output logic [HI_W-1:0] hi,
  output logic            half_end
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;

  assign half_end = busy && (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      chan  <= '0;
      hi    <= '0;
      div_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        chan  <= '0;
        hi    <= '0;
        div_q <= '0;
      end
    end else if (half_end) begin
      div_q <= '0;
      if (hi == HI_W'(HALVES_TOTAL - 1)) begin
        hi <= '0;
        if (chan == CH_W'(N_CH - 1)) busy <= 1'b0;
        else                         chan <= chan + 1'b1;
      end else begin
        hi <= hi + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_serdes.sv
module adc_seq_serdes
  import adc_seq_pkg::*;
#(
  parameter bit SGL_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [CH_W-1:0]   chan,
  input  logic [HI_W-1:0]   hi,
  input  logic              half_end,
  input  logic              adc_dout,
  output logic              sclk,
  output logic              cs_n,
  output logic              din,
  output logic              rise_evt,
  output logic              done_evt,
  output logic [DATA_W-1:0] data,
  output logic [CH_W-1:0]   data_chan,
  output logic              data_valid
);
  logic              active;
  logic [HI_W-2:0]   bit_idx;
  logic [CFG_W-1:0]  cfg;
  logic [DATA_W-1:0] shreg;

  assign active   = busy && (hi < HI_W'(HALVES_ACTIVE));
  assign bit_idx  = hi[HI_W-1:1];
  assign cfg      = cfg_word(SGL_MODE, chan);
  assign sclk     = active && hi[0];
  assign cs_n     = !active;
  assign din      = active && (int'(bit_idx) < CFG_W) && cfg[CFG_W - 1 - int'(bit_idx)];
  assign rise_evt = half_end && active && !hi[0];
  assign done_evt = half_end && (hi == HI_W'(HALVES_ACTIVE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      data       <= '0;
      data_chan  <= '0;
      data_valid <= 1'b0;
    end else begin
      if (rise_evt && (int'(bit_idx) >= CFG_W))
        shreg <= {shreg[DATA_W-2:0], adc_dout};
      data_valid <= done_evt;
      if (done_evt) begin
        data      <= shreg;
        data_chan <= chan;
      end
    end
  end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV     = 8,
  parameter bit SGL_MODE     = 1'b1,
  parameter int FRAME_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              adc_dout,
  output logic              adc_sclk,
  output logic              adc_cs_n,
  output logic              adc_din,
  output logic [DATA_W-1:0] smp_data,
  output logic [CH_W-1:0]   smp_chan,
  output logic              smp_valid
);
  logic            busy;
  logic [CH_W-1:0] chan;
  logic [HI_W-1:0] hi;
  logic            half_end;
  logic            rise_evt;
  logic            done_evt;

  adc_seq_timer #(.HALF_DIV(HALF_DIV)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frame_tick),
    .busy     (busy),
    .chan     (chan),
    .hi       (hi),
    .half_end (half_end)
  );

  adc_seq_serdes #(.SGL_MODE(SGL_MODE)) serdes_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .chan       (chan),
    .hi         (hi),
    .half_end   (half_end),
    .adc_dout   (adc_dout),
    .sclk       (adc_sclk),
    .cs_n       (adc_cs_n),
    .din        (adc_din),
    .rise_evt   (rise_evt),
    .done_evt   (done_evt),
    .data       (smp_data),
    .data_chan  (smp_chan),
    .data_valid (smp_valid)
  );
endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk #(
  parameter int FRAME_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic busy,
  input logic adc_sclk,
  input logic adc_cs_n,
  input logic adc_din,
  input logic smp_valid
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  // R2
  tick_opens_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_tick) |=> !adc_cs_n);

  // R3
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);

  // R4
  din_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_din) |-> !adc_sclk);

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R6
  valid_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> adc_cs_n);

  // R9
  sweep_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < FRAME_CYCLES));
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(.FRAME_CYCLES(FRAME_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .busy       (busy),
  .adc_sclk   (adc_sclk),
  .adc_cs_n   (adc_cs_n),
  .adc_din    (adc_din),
  .smp_valid  (smp_valid)
);

// File: tb/adc_conv_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_conv_sequencer_tb_top;
  localparam int H     = 8;
  localparam int FRAME = 5000;
  localparam int CONV  = 28 * H;
  localparam int SWEEP = 4 * CONV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic adc_dout = 1'b0;
  logic adc_sclk, adc_cs_n, adc_din, smp_valid;
  logic [7:0] smp_data;
  logic [1:0] smp_chan;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer #(.HALF_DIV(H), .SGL_MODE(1'b1), .FRAME_CYCLES(FRAME)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .adc_dout(adc_dout),
    .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_din(adc_din),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid)
  );

  function automatic logic [7:0] sample_val(input int ch, input int fr);
    if (fr % 4 == 1) return (ch % 2 == 1) ? 8'hFF : 8'h00;
    return 8'((ch * 67 + fr * 29 + 5) % 256);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // timeline reference: cycles elapsed since the sweep began
  bit m_busy = 1'b0;
  int m_t = 0;
  int m_frame = -1;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_t <= 0;
    end else if (!m_busy) begin
      if (frame_tick) begin
        m_busy <= 1'b1;
        m_t <= 0;
        m_frame <= m_frame + 1;
      end
    end else if (m_t == SWEEP - 1) begin
      m_busy <= 1'b0;
    end else begin
      m_t <= m_t + 1;
    end
  end

  // converter model: decodes the address it receives, returns bytes MSB first on falling edges
  logic prev_sclk = 1'b0;
  int rc = 0;
  logic [4:0] cfg_rx = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int r, c, k;
      bit e_act, e_sclk, e_din, e_valid;
      logic [4:0] e_cfg;
      r = m_t % CONV;
      c = m_t / CONV;
      k = r / (2 * H);
      e_cfg = {1'b1, 1'b1, 1'b0, 2'(c)};
      e_act = m_busy && (r < 26 * H);
      e_sclk = e_act && ((r / H) % 2 == 1);
      e_din = e_act && (k < 5) && e_cfg[4 - k];
      e_valid = m_busy && (r == 26 * H);
      // R2 R7 chip select timeline
      check("R2/R7", "adc_cs_n", int'(adc_cs_n), int'(!e_act));
      // R3 serial clock phases
      check("R3", "adc_sclk", int'(adc_sclk), int'(e_sclk));
      // R4 setup word bits
      check("R4", "adc_din", int'(adc_din), int'(e_din));
      // R6 strobe timing, R8 ticks during a sweep leave the timeline unchanged
      check("R6/R8", "smp_valid", int'(smp_valid), int'(e_valid));
      if (smp_valid && e_valid) begin
        // R5 result byte, R2 channel order
        check("R5", "smp_data", int'(smp_data), int'(sample_val(c, m_frame)));
        check("R2", "smp_chan", int'(smp_chan), c);
        // R9 sweep finishes inside the frame
        if (c == 3) check("R9", "sweep length within frame", int'(m_t + 2 * H < FRAME), 1);
      end
      // converter side
      if (adc_cs_n) begin
        rc = 0;
        adc_dout <= 1'b0;
      end else if (adc_sclk && !prev_sclk) begin
        if (rc < 5) cfg_rx = {cfg_rx[3:0], adc_din};
        rc++;
      end else if (!adc_sclk && prev_sclk && rc >= 5 && rc < 13) begin
        adc_dout <= sample_val(int'(cfg_rx[1:0]), m_frame)[12 - rc];
      end
      prev_sclk = adc_sclk;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait_cycles(3);
    // R1 reset state
    check("R1", "cs_n in reset", int'(adc_cs_n), 1);
    check("R1", "sclk in reset", int'(adc_sclk), 0);
    check("R1", "din in reset", int'(adc_din), 0);
    check("R1", "valid in reset", int'(smp_valid), 0);
    rst_n = 1'b1;
    wait_cycles(20);
    // R1 idle without a tick
    check("R1", "cs_n idle", int'(adc_cs_n), 1);
    // sweep 0: mixed bytes
    pulse_tick();
    wait_cycles(SWEEP + 50);
    // sweep 1: all-zero / all-one bytes, R8 extra ticks mid-sweep
    pulse_tick();
    wait_cycles(300);
    pulse_tick();
    wait_cycles(CONV);
    pulse_tick();
    wait_cycles(SWEEP);
    // R8 stray ticks left no activity after the sweep
    check("R8", "cs_n idle after sweep", int'(adc_cs_n), 1);
    // sweeps 2..4: tick held high, back-to-back
    frame_tick = 1'b1;
    wait_cycles(3 * SWEEP - 10);
    frame_tick = 1'b0;
    wait_cycles(SWEEP + 50);
    // R7 idle after last channel
    check("R7", "cs_n idle at end", int'(adc_cs_n), 1);
    finish_run();
  end

  initial begin
    wait_cycles(150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule